// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of a synchronous DRAM and keeps the array refreshed. It owns the command pins (chip select, row strobe, column strobe, write enable and clock enable) whenever refresh work is in progress. Whenever it drives them it keeps the required idle spacing after every refresh command. The main controller sees a request output, answers with a grant once it has stopped issuing its own commands, and treats a busy output as "do not touch the bus".

Two refresh policies are chosen at compile time. In distributed mode one refresh is owed per refresh interval. In burst mode a complete burst of refresh commands is owed once per retention window. The sequencer also takes the memory into and out of self refresh on a level request. On the way out it raises clock enable and waits out the row-cycle time with NOPs. In burst mode it then runs a full burst straight away.

All timing comes from parameters in nanoseconds. The spacing in cycles is the row-cycle time divided by the clock period, rounded up. The interval counters use the interval divided by the clock period, rounded down.

Top module: `refresh_sequencer`

## Requirements
- R1: A refresh command drives cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1 for exactly one cycle. From idle it appears in the cycle after a clock edge at which ref_grant_i, banks_idle_i and an owed request are all high, with cke high in the cycle before.
- R2: While ref_grant_i or banks_idle_i is low, no refresh or self-refresh entry is started, and ref_req_o remains high.
- R3: Two refresh commands are at least TRC_CYC = ceil(TRC_NS/CLK_PERIOD_NS) cycles apart. Between them the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, cke=1). Inside a burst the distance is exactly TRC_CYC.
- R4: In distributed mode (BURST_MODE=0) one refresh becomes owed every floor(REFI_NS/CLK_PERIOD_NS) cycles. ref_req_o is high in idle while a refresh is owed or sr_req_i is high.
- R5: In burst mode (BURST_MODE=1) a burst of BURST_COUNT refresh commands, spaced TRC_CYC apart, becomes owed every floor(BURST_WINDOW_NS/CLK_PERIOD_NS) cycles.
- R6: busy_o is high from a command cycle through the last NOP of its spacing and throughout self refresh. It is low in idle.
- R7: If sr_req_i is high when a start is granted, the self-refresh entry command (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=0) is issued instead of a refresh, and any owed refresh is dropped.
- R8: While in self refresh, cke=0 and cs_n, ras_n, cas_n, we_n are all 1 until sr_req_i is sampled low.
- R9: On leaving self refresh, cke returns high and NOP is driven for TRC_CYC cycles before any further command.
- R10: After self-refresh exit, burst mode issues a full burst immediately. Distributed mode returns to idle, and its interval count restarts at exit.
- R11: After reset the pins carry NOP with cke=1, and busy_o and ref_req_o are low.
- R12: Several interval expiries while a start is withheld collapse into a single owed refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| banks_idle_i | input | 1 | All banks precharged and idle |
| sr_req_i | input | 1 | Level request to be in self refresh |
| ref_grant_i | input | 1 | Controller has released the command bus |
| ref_req_o | output | 1 | Sequencer wants the bus (refresh owed or self refresh asked) |
| busy_o | output | 1 | Sequencer owns the command pins |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |

## Verification
The bench runs a distributed-mode and a burst-mode instance side by side on the same stimulus and targets the hand-over points. The first is a grant withheld across two interval expiries: a design that counts owed refreshes would issue two commands where one is due. The second is a grant given while banks are busy: a design that ignores the bank status would refresh into open rows. The third is a self-refresh request arriving while a refresh is owed: a design without the right priority would emit a refresh first, or would keep the stale debt after exit. The last is the exit path itself: a design that counted tRC down instead of up, or skipped the post-exit burst, would show a NOP window one cycle short or a missing burst of four commands.

// File: rtl/refresh_seq_pkg.sv
`timescale 1ns/1ps
// refresh_seq_pkg: shared types and helpers for the refresh sequencer.
// Assumes: all timing parameters are positive integers in nanoseconds.
package refresh_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_GAP,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
    } dram_pins_t;

    // Integer division rounded toward the next integer.
    function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Counter width for values 0..v-1, never below one bit.
    function automatic int unsigned width_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
`timescale 1ns/1ps
// refresh_interval_timer: free-running down counter that flags one cycle
// every PERIOD_CYC cycles. A restart holds it at its reload value.
// Assumes: PERIOD_CYC >= 2.
module refresh_interval_timer
    import refresh_seq_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic due_o
);
    localparam int unsigned CW = width_for(PERIOD_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count down, reloading at zero or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (restart_i || (cnt_q == '0)) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag for the cycle in which the count sits at zero.
    always_comb begin
        due_o = (cnt_q == '0) && !restart_i;
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD); // R4

endmodule

// File: rtl/refresh_spacing_counter.sv
`timescale 1ns/1ps
// refresh_spacing_counter: loadable down counter used to time NOP windows.
// It stops at zero and reports zero combinationally.
// Assumes: load values never exceed MAX_CYC - 1.
module refresh_spacing_counter
    import refresh_seq_pkg::*;
#(
    parameter int unsigned MAX_CYC = 14,
    localparam int unsigned CW = width_for(MAX_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero flag for the sequencer.
    always_comb begin
        zero_o = (cnt_q == '0);
    end

    AST_SPACING_LOAD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_val_i < CW'(MAX_CYC))); // R3

endmodule

// File: rtl/refresh_cmd_encoder.sv
`timescale 1ns/1ps
// refresh_cmd_encoder: maps the sequencer state to the DRAM pin levels.
// Assumes: idle, gap and exit cycles all carry NOP with clock enable high.
module refresh_cmd_encoder
    import refresh_seq_pkg::*;
(
    input  seq_state_e state_i,
    output dram_pins_t pins_o
);
    // One pin pattern per state.
    always_comb begin
        unique case (state_i)
            ST_REF:      pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b1};
            ST_SR_ENTER: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b0};
            ST_SR_HOLD:  pins_o = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b0};
            default:     pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
        endcase
    end
endmodule

// File: rtl/refresh_sequencer.sv
`timescale 1ns/1ps
// refresh_sequencer: owes refreshes on a timer (one per interval, or a
// full burst per retention window), asks the controller for the bus,
// issues them with row-cycle NOP spacing, and runs self-refresh entry,
// hold and exit (with a post-exit burst in burst mode).
// Assumes: the controller only raises ref_grant_i when it issues nothing
// itself, and keeps off the pins while busy_o is high.
module refresh_sequencer
    import refresh_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS   = 5,
    parameter int unsigned TRC_NS          = 70,
    parameter int unsigned REFI_NS         = 15600,
    parameter int unsigned BURST_WINDOW_NS = 16000000,
    parameter bit          BURST_MODE      = 1'b0,
    parameter int unsigned BURST_COUNT     = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_idle_i,
    input  logic sr_req_i,
    input  logic ref_grant_i,
    output logic ref_req_o,
    output logic busy_o,
    output logic cs_n_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic cke_o
);
    localparam int unsigned TRC_CYC      = div_ceil(TRC_NS, CLK_PERIOD_NS);
    localparam int unsigned SPACE_MAX    = (TRC_CYC < 2) ? 2 : TRC_CYC;
    localparam int unsigned SCW          = width_for(SPACE_MAX);
    localparam int unsigned INTERVAL_CYC = BURST_MODE ? (BURST_WINDOW_NS / CLK_PERIOD_NS)
                                                      : (REFI_NS / CLK_PERIOD_NS);
    localparam logic [SCW-1:0] GAP_LOAD  = SCW'(SPACE_MAX - 2);
    localparam logic [SCW-1:0] EXIT_LOAD = SCW'(SPACE_MAX - 1);

    seq_state_e state_q, state_d;
    dram_pins_t pins;
    logic       pending_q;
    logic       cke_prev_q;
    logic       due;
    logic       space_zero;
    logic       space_load;
    logic [SCW-1:0] space_val;
    logic       go;
    logic       in_sr_phase;
    logic       more_in_burst;
    logic       burst_load;
    logic       burst_step;

    // Start condition: idle, bus granted, banks idle, device awake, work owed.
    always_comb begin
        go = (state_q == ST_IDLE) && ref_grant_i && banks_idle_i && cke_prev_q
             && (pending_q || sr_req_i);
        in_sr_phase = (state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD)
                      || (state_q == ST_SR_EXIT);
    end

    refresh_interval_timer #(
        .PERIOD_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (in_sr_phase),
        .due_o     (due)
    );

    refresh_spacing_counter #(
        .MAX_CYC (SPACE_MAX)
    ) u_space (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (space_load),
        .load_val_i (space_val),
        .zero_o     (space_zero)
    );

    // Spacing loads: after a refresh command, and when leaving self refresh.
    always_comb begin
        space_load = (state_q == ST_REF) || ((state_q == ST_SR_HOLD) && !sr_req_i);
        space_val  = (state_q == ST_REF) ? GAP_LOAD : EXIT_LOAD;
        burst_load = (go && !sr_req_i) || ((state_q == ST_SR_EXIT) && space_zero);
        burst_step = (state_q == ST_GAP) && space_zero && more_in_burst;
    end

    // Burst bookkeeping only exists when burst mode is selected.
    generate
        if (BURST_MODE) begin : g_burst
            localparam int unsigned BCW = width_for(BURST_COUNT);
            logic [BCW-1:0] left_q;

            // Commands still to follow the current one in this burst.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q <= '0;
                end else if (burst_load) begin
                    left_q <= BCW'(BURST_COUNT - 1);
                end else if (burst_step) begin
                    left_q <= left_q - 1'b1;
                end
            end

            assign more_in_burst = (left_q != '0);
        end else begin : g_single
            assign more_in_burst = 1'b0;
        end
    endgenerate

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go) state_d = sr_req_i ? ST_SR_ENTER : ST_REF;
            ST_REF:      state_d = ST_GAP;
            ST_GAP:      if (space_zero) state_d = more_in_burst ? ST_REF : ST_IDLE;
            ST_SR_ENTER: state_d = ST_SR_HOLD;
            ST_SR_HOLD:  if (!sr_req_i) state_d = ST_SR_EXIT;
            ST_SR_EXIT:  if (space_zero) state_d = BURST_MODE ? ST_REF : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State, owed-refresh flag and previous clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pending_q  <= 1'b0;
            cke_prev_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            pending_q  <= (pending_q && !go) || due;
            cke_prev_q <= pins.cke;
        end
    end

    refresh_cmd_encoder u_enc (
        .state_i (state_q),
        .pins_o  (pins)
    );

    // Port drive.
    always_comb begin
        cs_n_o    = pins.cs_n;
        ras_n_o   = pins.ras_n;
        cas_n_o   = pins.cas_n;
        we_n_o    = pins.we_n;
        cke_o     = pins.cke;
        busy_o    = (state_q != ST_IDLE);
        ref_req_o = (state_q == ST_IDLE) && (pending_q || sr_req_i);
    end

    // Checker support: cycles since the last refresh command, saturating.
    logic is_ref_cmd;
    logic [SCW-1:0] since_ref_q;
    assign is_ref_cmd = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o && cke_o;

    // Track distance between refresh commands for the spacing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref_q <= SCW'(SPACE_MAX - 1);
        end else if (is_ref_cmd) begin
            since_ref_q <= SCW'(1);
        end else if (since_ref_q < SCW'(SPACE_MAX - 1)) begin
            since_ref_q <= since_ref_q + 1'b1;
        end
    end

    AST_REF_AFTER_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref_cmd |-> $past(cke_o)); // R1
    AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_REF || state_q == ST_SR_ENTER) && $past(state_q) == ST_IDLE)
        |-> $past(ref_grant_i && banks_idle_i)); // R2
    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref_cmd && (TRC_CYC >= 2)) |-> (since_ref_q >= SCW'(TRC_CYC - 1))); // R3
    AST_BUSY_WHILE_OWNING: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref_cmd || !cke_o) |-> busy_o); // R6
    AST_SR_HOLD_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && $past(!cke_o)) |-> (cs_n_o || !$past(cs_n_o))); // R8
    AST_EXIT_STARTS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (!cs_n_o && ras_n_o && cas_n_o && we_n_o && busy_o)); // R9

endmodule

// File: tb/refresh_sequencer_tb_top.sv
`timescale 1ns/1ps
// Behavioural reference: keeps a queue of the expected per-cycle activity.
module refresh_seq_model #(
    parameter int TRC_CYC      = 5,
    parameter int INTERVAL_CYC = 100,
    parameter bit BURST_MODE   = 1'b0,
    parameter int BURST_COUNT  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       banks_idle,
    input  logic       sr_req,
    input  logic       grant,
    output logic [4:0] exp_pins,
    output logic       exp_req,
    output logic       exp_busy,
    output int         exp_kind
);
    localparam int K_IDLE = 0, K_REF = 1, K_GAP = 2, K_SRE = 3, K_SR = 4, K_SRX = 5;
    int cur;
    int nxt;
    int tmr;
    bit pend;
    bit srph;
    bit start;
    int q[$];

    task automatic push_refs();
        int n;
        n = BURST_MODE ? BURST_COUNT : 1;
        for (int i = 0; i < n; i++) begin
            q.push_back(K_REF);
            for (int j = 1; j < TRC_CYC; j++) q.push_back(K_GAP);
        end
    endtask

    initial begin
        cur = K_IDLE; tmr = INTERVAL_CYC - 1; pend = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cur = K_IDLE; q.delete(); tmr = INTERVAL_CYC - 1; pend = 0;
        end else begin
            srph  = (cur == K_SRE) || (cur == K_SR) || (cur == K_SRX);
            start = (cur == K_IDLE) && grant && banks_idle && (pend || sr_req);
            if (cur == K_SR) begin
                if (!sr_req) begin
                    for (int j = 0; j < TRC_CYC; j++) q.push_back(K_SRX);
                    if (BURST_MODE) push_refs();
                    nxt = q.pop_front();
                end else nxt = K_SR;
            end else if (q.size() > 0) begin
                nxt = q.pop_front();
            end else if (start) begin
                if (sr_req) begin
                    nxt = K_SRE; q.push_back(K_SR);
                end else begin
                    push_refs(); nxt = q.pop_front();
                end
            end else nxt = K_IDLE;
            if (start) pend = 0;
            if (srph) tmr = INTERVAL_CYC - 1;
            else if (tmr == 0) begin tmr = INTERVAL_CYC - 1; pend = 1; end
            else tmr = tmr - 1;
            cur = nxt;
        end
    end

    always_comb begin
        case (cur)
            K_REF:   exp_pins = 5'b00011;
            K_SRE:   exp_pins = 5'b00010;
            K_SR:    exp_pins = 5'b11110;
            default: exp_pins = 5'b01111;
        endcase
        exp_req  = (cur == K_IDLE) && (pend || sr_req);
        exp_busy = (cur != K_IDLE);
        exp_kind = cur;
    end
endmodule

module refresh_sequencer_tb_top;
    localparam int CLK_NS = 5;
    localparam int TRC_NS = 22;
    localparam int TRC_CYC = (TRC_NS + CLK_NS - 1) / CLK_NS;
    localparam int REFI_NS = 500;
    localparam int WIN_NS = 1500;
    localparam int BCNT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b1;
    logic sr_req = 1'b0;
    logic grant = 1'b0;

    logic req_d, busy_d, cs_d, ras_d, cas_d, we_d, cke_d;
    logic req_b, busy_b, cs_b, ras_b, cas_b, we_b, cke_b;
    logic [4:0] ep_d, ep_b;
    logic er_d, eb_d, er_b, eb_b;
    int ek_d, ek_b;

    int n_checks = 0;
    int n_fail = 0;
    bit cmp_en = 0;
    int ref_d = 0, ref_b = 0, sre_d = 0, sre_b = 0;

    always #2.5 clk = ~clk;

    refresh_sequencer #(.CLK_PERIOD_NS(CLK_NS), .TRC_NS(TRC_NS), .REFI_NS(REFI_NS),
        .BURST_WINDOW_NS(WIN_NS), .BURST_MODE(1'b0), .BURST_COUNT(BCNT)) dut_i (
        .clk(clk), .rst_n(rst_n), .banks_idle_i(banks_idle), .sr_req_i(sr_req),
        .ref_grant_i(grant), .ref_req_o(req_d), .busy_o(busy_d), .cs_n_o(cs_d),
        .ras_n_o(ras_d), .cas_n_o(cas_d), .we_n_o(we_d), .cke_o(cke_d));

    refresh_sequencer #(.CLK_PERIOD_NS(CLK_NS), .TRC_NS(TRC_NS), .REFI_NS(REFI_NS),
        .BURST_WINDOW_NS(WIN_NS), .BURST_MODE(1'b1), .BURST_COUNT(BCNT)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .banks_idle_i(banks_idle), .sr_req_i(sr_req),
        .ref_grant_i(grant), .ref_req_o(req_b), .busy_o(busy_b), .cs_n_o(cs_b),
        .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b), .cke_o(cke_b));

    refresh_seq_model #(.TRC_CYC(TRC_CYC), .INTERVAL_CYC(REFI_NS / CLK_NS),
        .BURST_MODE(1'b0), .BURST_COUNT(BCNT)) mdl_d (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sr_req(sr_req), .grant(grant),
        .exp_pins(ep_d), .exp_req(er_d), .exp_busy(eb_d), .exp_kind(ek_d));

    refresh_seq_model #(.TRC_CYC(TRC_CYC), .INTERVAL_CYC(WIN_NS / CLK_NS),
        .BURST_MODE(1'b1), .BURST_COUNT(BCNT)) mdl_b (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sr_req(sr_req), .grant(grant),
        .exp_pins(ep_b), .exp_req(er_b), .exp_busy(eb_b), .exp_kind(ek_b));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int kind);
        case (kind)
            1: return "R1";
            2: return "R3";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            default: return "R6";
        endcase
    endfunction

    // Per-cycle comparison against both reference models, mid-cycle.
    always @(negedge clk) begin
        if (cmp_en) begin
            check({cs_d, ras_d, cas_d, we_d, cke_d} == ep_d, tag_of(ek_d), "dist pins",
                  {cs_d, ras_d, cas_d, we_d, cke_d}, ep_d);
            check(req_d == er_d, "R4", "dist ref_req", req_d, er_d);
            check(busy_d == eb_d, "R6", "dist busy", busy_d, eb_d);
            check({cs_b, ras_b, cas_b, we_b, cke_b} == ep_b, tag_of(ek_b), "burst pins",
                  {cs_b, ras_b, cas_b, we_b, cke_b}, ep_b);
            check(req_b == er_b, "R5", "burst ref_req", req_b, er_b);
            check(busy_b == eb_b, "R6", "burst busy", busy_b, eb_b);
            if ({cs_d, ras_d, cas_d, we_d, cke_d} == 5'b00011) ref_d++;
            if ({cs_b, ras_b, cas_b, we_b, cke_b} == 5'b00011) ref_b++;
            if ({cs_d, ras_d, cas_d, we_d, cke_d} == 5'b00010) sre_d++;
            if ({cs_b, ras_b, cas_b, we_b, cke_b} == 5'b00010) sre_b++;
        end
    end

    task automatic clear_counts();
        ref_d = 0; ref_b = 0; sre_d = 0; sre_b = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * CLK_NS);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check({cs_d, ras_d, cas_d, we_d, cke_d} == 5'b01111, "R11", "dist pins", {cs_d, ras_d, cas_d, we_d, cke_d}, 15);
        check(!busy_d && !req_d, "R11", "dist busy/req", {busy_d, req_d}, 0);
        check({cs_b, ras_b, cas_b, we_b, cke_b} == 5'b01111, "R11", "burst pins", {cs_b, ras_b, cas_b, we_b, cke_b}, 15);
        check(!busy_b && !req_b, "R11", "burst busy/req", {busy_b, req_b}, 0);
        cmp_en = 1;
        step(1);

        // Free-running with the bus granted.
        grant = 1'b1; clear_counts();
        step(340);
        check(ref_d == 3, "R4", "dist refreshes in 340 cycles", ref_d, 3);
        check(ref_b == BCNT, "R5", "burst refreshes in 340 cycles", ref_b, BCNT);

        // Grant withheld across two interval expiries.
        grant = 1'b0; clear_counts();
        step(250);
        check(ref_d == 0, "R2", "dist refreshes without grant", ref_d, 0);
        check(ref_b == 0, "R2", "burst refreshes without grant", ref_b, 0);
        check(req_d == 1'b1, "R2", "dist ref_req held", req_d, 1);
        grant = 1'b1; clear_counts();
        step(5);
        check(ref_d == 1, "R12", "dist refreshes after late grant", ref_d, 1);

        // Granted but banks open.
        banks_idle = 1'b0; clear_counts();
        step(150);
        check(ref_d == 0, "R2", "dist refreshes with banks open", ref_d, 0);
        check(ref_b == 0, "R2", "burst refreshes with banks open", ref_b, 0);

        // Self refresh requested while refreshes are owed.
        banks_idle = 1'b1; sr_req = 1'b1; clear_counts();
        step(60);
        check(sre_d == 1, "R7", "dist self-refresh entries", sre_d, 1);
        check(sre_b == 1, "R7", "burst self-refresh entries", sre_b, 1);
        check(ref_d == 0 && ref_b == 0, "R7", "refreshes before entry", ref_d + ref_b, 0);
        check(cke_d == 1'b0 && cke_b == 1'b0, "R8", "cke in self refresh", cke_d + cke_b, 0);
        sr_req = 1'b0; clear_counts();
        step(40);
        check(ref_d == 0, "R10", "dist refreshes after exit", ref_d, 0);
        check(ref_b == BCNT, "R10", "burst refreshes after exit", ref_b, BCNT);
        check(busy_d == 1'b0 && busy_b == 1'b0, "R6", "busy after exit work", busy_d + busy_b, 0);

        step(20);
        cmp_en = 0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule